// File: doc/BRIEF.md
# Camera Serial Receiver Control and Status Registers

This block is the software-visible register file of a serial camera receiver. A simple 32-bit bus port reads and writes four configuration words: global control, PHY lane control, stream configuration and frame size. It also reads and writes an interrupt mask word and an interrupt source word. The block collects single-cycle event pulses from the receive datapath into the source word. It raises one interrupt line while any unmasked source bit is set.

Configuration writes land in a staging copy that the datapath never sees. The datapath only sees the active copy. Software moves staging into active by setting the self-clearing update bit in the control word. If the active copy has the receiver disabled, the transfer happens on the next clock. Otherwise it waits for the next frame-start pulse, so the settings never change in the middle of a frame. A self-clearing soft-reset bit returns every register except the interrupt mask to zero.

Top module: `camrx_csr`

## Requirements
- R1: After reset every readable word is zero, `irq` is low, and every `act_*` output is zero.
- R2: The bus decodes the following fields, and every other bit of these words reads back as zero.
  - Word 0x00: enable in bit 0, external wrapper clock in bit 8, 32-bit alignment in bit 20, lane swap in bit 31. Bit 16 reads 1 while an update is pending.
  - Word 0x04: settle count in bits 31:27, lane enables in bits 4:0.
  - Word 0x08: lane count minus one in bits 1:0, data-type code in bits 7:2.
  - Word 0x2C: width in bits 31:16, height in bits 15:0.
- R3: Writes to the configuration words change no `act_*` output until an update is requested and carried out.
- R4: A write to word 0x00 with bit 16 set requests an update. While the active enable is 0, the staging values appear on `act_*` one clock after that write, and bit 16 then reads 0 again.
- R5: While the active enable is 1, a requested update stays pending (bit 16 reads 1) until `ev_frame_start` is high at a clock edge. The new values appear on `act_*` after that edge.
- R6: The source word at 0x14 latches event pulses at fixed positions, and a latched bit holds until it is cleared:
  - `ev_frame_start` at bit 27, `ev_frame_end` at bit 26;
  - `ev_nonimg[3:0]` at bits 31:28;
  - `ev_sot_err[i]` at bit 12+i;
  - `ev_err[5:0]` at bits 5:0.
- R7: Writing 1 to a source bit clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as the clear leaves that bit set.
- R8: The mask word at 0x10 stores only bits that exist in the source word (0xFC00F03F with four lanes). `irq` is high exactly when the source and mask words share a set bit.
- R9: A write to word 0x00 with bit 4 set clears staging, active, pending and source state. The mask keeps its value, and bit 4 always reads 0.
- R10: Addresses other than 0x00, 0x04, 0x08, 0x10, 0x14 and 0x2C read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_frame_start | input | 1 | Frame-start pulse from datapath |
| ev_frame_end | input | 1 | Frame-end pulse from datapath |
| ev_nonimg | input | 4 | Non-image data pulses (odd after, odd before, even after, even before) |
| ev_sot_err | input | NUM_LANES | Per-lane start-of-transmission error pulses |
| ev_err | input | 6 | Lost frame start, lost frame end, overflow, ECC, CRC, unknown (bits 5 to 0) |
| act_enable | output | 1 | Active receiver enable |
| act_ext_clk | output | 1 | Active external wrapper clock select |
| act_align32 | output | 1 | Active 32-bit data alignment |
| act_swap | output | 1 | Active differential pair swap |
| act_settle | output | 5 | Active HS receive settle count |
| act_lane_en | output | 5 | Active lane enables, clock lane included |
| act_lane_cnt | output | 2 | Active data lane count minus one |
| act_dtype | output | 6 | Active data-type code |
| act_width | output | 16 | Active frame width |
| act_height | output | 16 | Active frame height |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default ADDR_W of 8 and NUM_LANES of 4. With these values all four per-lane start-of-transmission bits exist, so the full 0xF03F error group can be set and masked. The 8-bit address covers every mapped word and leaves room for unmapped offsets such as 0x20. One lane pulse is checked at bit 14, the write-all-ones test of the mask exposes every implemented source position, and both branches of the update timing (receiver disabled, and waiting for frame start) are reached.

// File: rtl/camrx_csr_pkg.sv
package camrx_csr_pkg;

    localparam int WORD_W    = 32;
    localparam int SETTLE_W  = 5;
    localparam int LANE_EN_W = 5;
    localparam int LCNT_W    = 2;
    localparam int DT_W      = 6;
    localparam int DIM_W     = 16;

    // word offsets
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_PHY  = 'h04;
    localparam int OFS_CFG  = 'h08;
    localparam int OFS_MASK = 'h10;
    localparam int OFS_SRC  = 'h14;
    localparam int OFS_RES  = 'h2C;

    // control word bits
    localparam int CTRL_EN_B   = 0;
    localparam int CTRL_SRST_B = 4;
    localparam int CTRL_EXT_B  = 8;
    localparam int CTRL_UPD_B  = 16;
    localparam int CTRL_ALN_B  = 20;
    localparam int CTRL_SWAP_B = 31;

    localparam int PHY_SET_LSB = 27;
    localparam int CFG_DT_LSB  = 2;
    localparam int RES_W_LSB   = 16;

    // source word positions
    localparam int SRC_FE_B   = 26;
    localparam int SRC_FS_B   = 27;
    localparam int SRC_NI_LSB = 28;
    localparam int SRC_SOT_LSB = 12;
    localparam int SRC_ERR_W  = 6;

    typedef struct packed {
        logic                 swap;
        logic                 align32;
        logic                 ext_clk;
        logic                 enable;
        logic [SETTLE_W-1:0]  settle;
        logic [LANE_EN_W-1:0] lane_en;
        logic [LCNT_W-1:0]    lane_cnt;
        logic [DT_W-1:0]      dtype;
        logic [DIM_W-1:0]     width;
        logic [DIM_W-1:0]     height;
    } camrx_cfg_t;

    function automatic logic [WORD_W-1:0] src_valid(input int lanes);
        logic [WORD_W-1:0] m;
        m = '0;
        m[SRC_ERR_W-1:0] = '1;
        m[SRC_FE_B] = 1'b1;
        m[SRC_FS_B] = 1'b1;
        m[WORD_W-1:SRC_NI_LSB] = '1;
        for (int i = 0; i < lanes; i++) m[SRC_SOT_LSB+i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/camrx_csr_stage.sv
module camrx_csr_stage
    import camrx_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_phy,
    input  logic              wr_cfg,
    input  logic              wr_res,
    input  logic              srst,
    input  logic [WORD_W-1:0] wdata,
    output camrx_cfg_t        stage
);

    camrx_cfg_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (srst) begin
            stage_d = '0;
        end else begin
            if (wr_ctrl) begin
                stage_d.enable  = wdata[CTRL_EN_B];
                stage_d.ext_clk = wdata[CTRL_EXT_B];
                stage_d.align32 = wdata[CTRL_ALN_B];
                stage_d.swap    = wdata[CTRL_SWAP_B];
            end
            if (wr_phy) begin
                stage_d.settle  = wdata[PHY_SET_LSB +: SETTLE_W];
                stage_d.lane_en = wdata[LANE_EN_W-1:0];
            end
            if (wr_cfg) begin
                stage_d.lane_cnt = wdata[LCNT_W-1:0];
                stage_d.dtype    = wdata[CFG_DT_LSB +: DT_W];
            end
            if (wr_res) begin
                stage_d.width  = wdata[RES_W_LSB +: DIM_W];
                stage_d.height = wdata[DIM_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign stage = stage_q;

    // R9: soft reset empties the staging copy
    p_srst_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (stage_q == '0));

endmodule

// File: rtl/camrx_csr_shadow.sv
module camrx_csr_shadow
    import camrx_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  camrx_cfg_t stage,
    input  logic       upd_req,
    input  logic       frame_start,
    input  logic       srst,
    output camrx_cfg_t active,
    output logic       pend
);

    typedef struct packed {
        logic       pend;
        camrx_cfg_t act;
    } shadow_t;

    shadow_t sh_d, sh_q;
    logic    copy;

    always_comb begin
        sh_d = sh_q;
        copy = sh_q.pend && (frame_start || !sh_q.act.enable);
        if (srst) begin
            sh_d = '0;
        end else begin
            if (copy) begin
                sh_d.act  = stage;
                sh_d.pend = 1'b0;
            end
            if (upd_req) sh_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign active = sh_q.act;
    assign pend   = sh_q.pend;

    // R3: active copy moves only on a transfer or a soft reset
    p_hold_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy && !srst) |=> $stable(sh_q.act));

    // R4: with the receiver idle a pending update completes on the next edge
    p_idle_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.pend && !sh_q.act.enable && !srst && !upd_req)
        |=> (!sh_q.pend && sh_q.act == $past(stage)));

    // R5: while running the update waits for frame start
    p_wait_fs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.pend && sh_q.act.enable && !frame_start && !srst) |=> sh_q.pend);

endmodule

// File: rtl/camrx_csr_irq.sv
module camrx_csr_irq
    import camrx_csr_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_mask,
    input  logic                 wr_src,
    input  logic                 srst,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 ev_frame_start,
    input  logic                 ev_frame_end,
    input  logic [3:0]           ev_nonimg,
    input  logic [NUM_LANES-1:0] ev_sot_err,
    input  logic [SRC_ERR_W-1:0] ev_err,
    output logic [WORD_W-1:0]    mask,
    output logic [WORD_W-1:0]    src,
    output logic                 irq
);

    localparam logic [WORD_W-1:0] VALID = src_valid(NUM_LANES);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] src;
    } irq_t;

    irq_t              irq_d, irq_q;
    logic [WORD_W-1:0] ev_vec;
    logic [WORD_W-1:0] clr;

    always_comb begin
        ev_vec = '0;
        ev_vec[SRC_ERR_W-1:0]              = ev_err;
        ev_vec[SRC_SOT_LSB +: NUM_LANES]   = ev_sot_err;
        ev_vec[SRC_FE_B]                   = ev_frame_end;
        ev_vec[SRC_FS_B]                   = ev_frame_start;
        ev_vec[WORD_W-1:SRC_NI_LSB]        = ev_nonimg;

        clr   = wr_src ? wdata : '0;
        irq_d = irq_q;
        irq_d.src = ((irq_q.src & ~clr) | ev_vec) & VALID;
        if (wr_mask) irq_d.mask = wdata & VALID;
        if (srst)    irq_d.src  = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign mask = irq_q.mask;
    assign src  = irq_q.src;
    assign irq  = |(irq_q.src & irq_q.mask);

    // R7: an event beats a clear in the same cycle
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_start && !srst) |=> irq_q.src[SRC_FS_B]);

    // R7: written ones clear when no event arrives
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_src && !srst && ev_vec == '0) |=> ((irq_q.src & $past(wdata)) == '0));

    // R9: soft reset leaves the mask alone
    p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && !wr_mask) |=> $stable(irq_q.mask));

    // R8: a raised request needs both a source and a mask bit
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_q.src != '0 && irq_q.mask != '0));

endmodule

// File: rtl/camrx_csr.sv
module camrx_csr
    import camrx_csr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 ev_frame_start,
    input  logic                 ev_frame_end,
    input  logic [3:0]           ev_nonimg,
    input  logic [NUM_LANES-1:0] ev_sot_err,
    input  logic [5:0]           ev_err,
    output logic                 act_enable,
    output logic                 act_ext_clk,
    output logic                 act_align32,
    output logic                 act_swap,
    output logic [4:0]           act_settle,
    output logic [4:0]           act_lane_en,
    output logic [1:0]           act_lane_cnt,
    output logic [5:0]           act_dtype,
    output logic [15:0]          act_width,
    output logic [15:0]          act_height,
    output logic                 irq
);

    logic hit_ctrl, hit_phy, hit_cfg, hit_mask, hit_src, hit_res;
    logic srst, upd_req, pend;
    camrx_cfg_t        stage, active;
    logic [WORD_W-1:0] mask, src;

    assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_phy  = (bus_addr == ADDR_W'(OFS_PHY));
    assign hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
    assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
    assign hit_src  = (bus_addr == ADDR_W'(OFS_SRC));
    assign hit_res  = (bus_addr == ADDR_W'(OFS_RES));

    assign srst    = bus_wr && hit_ctrl && bus_wdata[CTRL_SRST_B];
    assign upd_req = bus_wr && hit_ctrl && bus_wdata[CTRL_UPD_B] && !srst;

    camrx_csr_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (bus_wr && hit_ctrl),
        .wr_phy  (bus_wr && hit_phy),
        .wr_cfg  (bus_wr && hit_cfg),
        .wr_res  (bus_wr && hit_res),
        .srst    (srst),
        .wdata   (bus_wdata),
        .stage   (stage)
    );

    camrx_csr_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .stage       (stage),
        .upd_req     (upd_req),
        .frame_start (ev_frame_start),
        .srst        (srst),
        .active      (active),
        .pend        (pend)
    );

    camrx_csr_irq #(.NUM_LANES(NUM_LANES)) u_irq (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_mask        (bus_wr && hit_mask),
        .wr_src         (bus_wr && hit_src),
        .srst           (srst),
        .wdata          (bus_wdata),
        .ev_frame_start (ev_frame_start),
        .ev_frame_end   (ev_frame_end),
        .ev_nonimg      (ev_nonimg),
        .ev_sot_err     (ev_sot_err),
        .ev_err         (ev_err),
        .mask           (mask),
        .src            (src),
        .irq            (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[CTRL_EN_B]   = stage.enable;
            bus_rdata[CTRL_EXT_B]  = stage.ext_clk;
            bus_rdata[CTRL_UPD_B]  = pend;
            bus_rdata[CTRL_ALN_B]  = stage.align32;
            bus_rdata[CTRL_SWAP_B] = stage.swap;
        end else if (hit_phy) begin
            bus_rdata[PHY_SET_LSB +: SETTLE_W] = stage.settle;
            bus_rdata[LANE_EN_W-1:0]           = stage.lane_en;
        end else if (hit_cfg) begin
            bus_rdata[LCNT_W-1:0]         = stage.lane_cnt;
            bus_rdata[CFG_DT_LSB +: DT_W] = stage.dtype;
        end else if (hit_res) begin
            bus_rdata[RES_W_LSB +: DIM_W] = stage.width;
            bus_rdata[DIM_W-1:0]          = stage.height;
        end else if (hit_mask) begin
            bus_rdata = mask;
        end else if (hit_src) begin
            bus_rdata = src;
        end
    end

    assign act_enable   = active.enable;
    assign act_ext_clk  = active.ext_clk;
    assign act_align32  = active.align32;
    assign act_swap     = active.swap;
    assign act_settle   = active.settle;
    assign act_lane_en  = active.lane_en;
    assign act_lane_cnt = active.lane_cnt;
    assign act_dtype    = active.dtype;
    assign act_width    = active.width;
    assign act_height   = active.height;

endmodule

// File: tb/camrx_csr_tb.sv
`timescale 1ns/1ps
module camrx_csr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_frame_start = 1'b0;
    logic        ev_frame_end = 1'b0;
    logic [3:0]  ev_nonimg = '0;
    logic [3:0]  ev_sot_err = '0;
    logic [5:0]  ev_err = '0;
    logic        act_enable, act_ext_clk, act_align32, act_swap;
    logic [4:0]  act_settle, act_lane_en;
    logic [1:0]  act_lane_cnt;
    logic [5:0]  act_dtype;
    logic [15:0] act_width, act_height;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    camrx_csr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_frame_start(ev_frame_start), .ev_frame_end(ev_frame_end),
        .ev_nonimg(ev_nonimg), .ev_sot_err(ev_sot_err), .ev_err(ev_err),
        .act_enable(act_enable), .act_ext_clk(act_ext_clk),
        .act_align32(act_align32), .act_swap(act_swap),
        .act_settle(act_settle), .act_lane_en(act_lane_en),
        .act_lane_cnt(act_lane_cnt), .act_dtype(act_dtype),
        .act_width(act_width), .act_height(act_height), .irq(irq)
    );

    // {addr, write data, expected readback}
    localparam logic [71:0] VECS [0:7] = '{
        {8'h00, 32'h8010_0101, 32'h8010_0101},
        {8'h04, 32'hFFFF_FFFF, 32'hF800_001F},
        {8'h08, 32'hFFFF_FFFF, 32'h0000_00FF},
        {8'h2C, 32'h1234_5678, 32'h1234_5678},
        {8'h10, 32'hFFFF_FFFF, 32'hFC00_F03F},
        {8'h14, 32'h0000_0000, 32'h0000_0000},
        {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h08, 32'h0000_00AD, 32'h0000_00AD}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(8'h00, 32'h0, "R1 ctrl");
        rd_chk(8'h04, 32'h0, "R1 phy");
        rd_chk(8'h08, 32'h0, "R1 cfg");
        rd_chk(8'h10, 32'h0, "R1 mask");
        rd_chk(8'h14, 32'h0, "R1 src");
        rd_chk(8'h2C, 32'h0, "R1 res");
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 active", {act_enable, act_settle, act_lane_en, act_dtype, act_width}, 32'h0);

        // R2 R8 R10 readback table
        for (int i = 0; i < 8; i++) begin
            wr(VECS[i][71:64], VECS[i][63:32]);
            rd_chk(VECS[i][71:64], VECS[i][31:0], $sformatf("R2/R8/R10 vec%0d", i));
        end
        rd_chk(8'h2C, 32'h1234_5678, "R10 unmapped write no effect");

        // R3 staging not yet active
        chk("R3 enable held", {31'b0, act_enable}, 32'h0);
        chk("R3 width held", {16'b0, act_width}, 32'h0);

        // R4 update while idle
        wr(8'h00, 32'h8011_0101);
        rd_chk(8'h00, 32'h8011_0101, "R4 pending visible");
        @(negedge clk);
        rd_chk(8'h00, 32'h8010_0101, "R4 self clear");
        chk("R4 ctrl bits", {28'b0, act_enable, act_ext_clk, act_align32, act_swap}, 32'hF);
        chk("R4 phy", {22'b0, act_settle, act_lane_en}, {22'b0, 5'h1F, 5'h1F});
        chk("R4 cfg", {24'b0, act_lane_cnt, act_dtype}, {24'b0, 2'b01, 6'h2B});
        chk("R4 res", {act_width, act_height}, 32'h1234_5678);

        // R5 update while running waits for frame start
        wr(8'h2C, 32'h0040_0030);
        wr(8'h00, 32'h0011_0001);
        repeat (3) @(negedge clk);
        rd_chk(8'h00, 32'h0011_0001, "R5 still pending");
        chk("R5 width held", {16'b0, act_width}, 32'h1234);
        ev_frame_start = 1'b1;
        @(negedge clk);
        ev_frame_start = 1'b0;
        #1;
        chk("R5 res applied", {act_width, act_height}, 32'h0040_0030);
        chk("R5 swap applied", {31'b0, act_swap}, 32'h0);
        rd_chk(8'h00, 32'h0010_0001, "R5 self clear");
        rd_chk(8'h14, 32'h0800_0000, "R6 frame start latched");
        chk("R8 irq set", {31'b0, irq}, 32'h1);

        // R6 R7 R8 sources
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h0, "R7 clear all");
        chk("R8 irq clear", {31'b0, irq}, 32'h0);
        @(negedge clk);
        ev_err = 6'b000100; ev_sot_err = 4'b0100; ev_nonimg = 4'b1000; ev_frame_end = 1'b1;
        @(negedge clk);
        ev_err = '0; ev_sot_err = '0; ev_nonimg = '0; ev_frame_end = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk(8'h14, 32'h8400_4004, "R6 event positions");
        wr(8'h10, 32'h0000_0004);
        #1 chk("R8 masked hit", {31'b0, irq}, 32'h1);
        wr(8'h10, 32'h0000_1000);
        #1 chk("R8 masked miss", {31'b0, irq}, 32'h0);
        wr(8'h14, 32'h0400_0000);
        rd_chk(8'h14, 32'h8000_4004, "R7 partial clear");
        @(negedge clk);
        bus_addr = 8'h14; bus_wdata = 32'h1; bus_wr = 1'b1; ev_err = 6'b000001;
        @(negedge clk);
        bus_wr = 1'b0; ev_err = '0;
        rd_chk(8'h14, 32'h8000_4005, "R7 set wins");

        // R9 soft reset
        wr(8'h10, 32'h0000_0001);
        #1 chk("R9 irq before", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0001_0010);
        rd_chk(8'h00, 32'h0, "R9 ctrl");
        rd_chk(8'h04, 32'h0, "R9 phy");
        rd_chk(8'h2C, 32'h0, "R9 res");
        rd_chk(8'h14, 32'h0, "R9 src");
        rd_chk(8'h10, 32'h1, "R9 mask kept");
        chk("R9 active", {act_enable, act_settle, act_lane_en, act_dtype, act_width}, 32'h0);
        chk("R9 irq", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule